// File: doc/BRIEF.md
# Window Limit Monitor with Early Out-of-Range Detection

The block watches the results of a successive-approximation conversion and decides whether each one lands inside or outside a window set by a high and a low limit. Result bits arrive most-significant first: each strobe on `bitValid` comes with `partRes`, which holds every bit resolved so far, left-aligned, with the unresolved low bits at zero. A pulse on `convStart` opens a new conversion and latches the channel number that the conversion belongs to.

When `outsideMode` is set, a hit means the result lies beyond the window. The block can call this after only the top four result bits. If those four bits do not settle the matter, it looks again once eight bits are known. When `outsideMode` is clear, a hit means the full result lies within the window, limits included. A hit raises a one-cycle interrupt pulse and sets that channel's flag in an eight-entry status register. Software clears flags by writing ones through `clrWe`/`clrMask`.

Top module: `limit_window_monitor`

## Requirements
- R1: With `outsideMode`=0, a hit is decided only on the last result bit (bit index RES_W-1 since `convStart`), and only when limLow <= result <= limHigh. A result equal to either limit is a hit.
- R2: With `outsideMode`=1, on the fourth bit strobe the top four bits of `partRes` are compared with the top four bits of each limit. Strictly greater than the high bits, or strictly less than the low bits, is a hit.
- R3: With `outsideMode`=1 and no early hit, on the eighth bit strobe the top eight bits of `partRes` are compared, strictly, with the top eight bits of each limit. The two lowest result bits are never used in this mode.
- R4: While `bndEn`=0, no interrupt is raised and no status flag is set.
- R5: At most one interrupt pulse is raised per conversion, even when a later check would also succeed.
- R6: A hit sets bit `chan` of `bndStatus`, where `chan` is the `chanSel` value latched at `convStart`. A cycle with `clrWe`=1 clears every status bit whose `clrMask` bit is 1 and leaves the others unchanged.
- R7: When a hit sets a status bit in the same cycle that a write clears it, the bit ends up set.
- R8: After reset, `bndIrq` is 0 and `bndStatus` is all zeros.
- R9: `bndIrq` is a single-cycle pulse, high in the cycle after the bit strobe that decided the hit. A `bitValid` that comes in the same cycle as `convStart` is ignored.
- R10: With `outsideMode`=0, no interrupt follows any bit strobe other than the last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| convStart | input | 1 | Opens a new conversion and latches `chanSel` |
| bitValid | input | 1 | One more result bit has been resolved |
| partRes | input | RES_W | Resolved result bits, left-aligned, low bits zero |
| chanSel | input | CHAN_W | Channel of the conversion being started |
| outsideMode | input | 1 | 1: hit means outside the window; 0: hit means inside |
| bndEn | input | 1 | Enables limit checking |
| limHigh | input | RES_W | Upper window limit |
| limLow | input | RES_W | Lower window limit |
| clrWe | input | 1 | Write strobe for clearing status flags |
| clrMask | input | CHAN_N | Ones select the status flags to clear |
| bndIrq | output | 1 | Boundary interrupt pulse |
| bndStatus | output | CHAN_N | Per-channel boundary hit flags |

## Verification
On every cycle the assertions check the following. A disabled monitor stays silent. A conversion that has already fired raises no second pulse. The decoding strobes never overlap. An inside-mode pulse only ever follows the last bit. A hit always leaves its channel's flag set, even against a clear, and a clear without a hit empties every bit it names. The bench scenarios are the only way to show the actual decisions. These include the bit on which a pulse appears for results above, below, inside and on the limits, and the case where the full result is out of range but its eight top bits equal the limit. They also cover how the status register builds up across channels.

// File: rtl/lwm_pkg.sv
package lwm_pkg;
  // Evaluation strobes handed from control to datapath
  typedef struct packed {
    logic evalEarly;   // top EARLY_W bits just resolved
    logic evalLate;    // top LATE_W bits just resolved
    logic evalFull;    // every result bit resolved
    logic newConv;     // a conversion is being opened
  } lwmStrobe_t;
endpackage

// File: rtl/lwm_ctrl.sv
module lwm_ctrl
  import lwm_pkg::*;
#(
  parameter int RES_W   = 10,
  parameter int EARLY_W = 4,
  parameter int LATE_W  = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       convStart,
  input  logic       bitValid,
  output lwmStrobe_t strobe
);
  localparam int CNT_W = $clog2(RES_W + 1);

  logic [CNT_W-1:0] bitCnt;
  logic             beat;

  assign beat = bitValid && !convStart;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (convStart) begin
      bitCnt <= '0;
    end else if (bitValid && (bitCnt != CNT_W'(RES_W))) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.newConv   = convStart;
    strobe.evalEarly = beat && (bitCnt == CNT_W'(EARLY_W - 1));
    strobe.evalLate  = beat && (bitCnt == CNT_W'(LATE_W - 1));
    strobe.evalFull  = beat && (bitCnt == CNT_W'(RES_W - 1));
  end

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.evalEarly, strobe.evalLate, strobe.evalFull}));

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(RES_W));
endmodule

// File: rtl/lwm_datapath.sv
module lwm_datapath
  import lwm_pkg::*;
#(
  parameter int RES_W   = 10,
  parameter int CHAN_N  = 8,
  parameter int EARLY_W = 4,
  parameter int LATE_W  = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  lwmStrobe_t                strobe,
  input  logic [RES_W-1:0]          partRes,
  input  logic [$clog2(CHAN_N)-1:0] chanSel,
  input  logic                      outsideMode,
  input  logic                      bndEn,
  input  logic [RES_W-1:0]          limHigh,
  input  logic [RES_W-1:0]          limLow,
  input  logic                      clrWe,
  input  logic [CHAN_N-1:0]         clrMask,
  output logic                      bndIrq,
  output logic [CHAN_N-1:0]         bndStatus
);
  localparam int CHAN_W = $clog2(CHAN_N);

  logic [CHAN_W-1:0] chanReg;
  logic              fired;
  logic              earlyOut, lateOut, fullIn, hit;
  logic [CHAN_N-1:0] chanOneHot;

  logic [EARLY_W-1:0] resTop4, hiTop4, loTop4;
  logic [LATE_W-1:0]  resTop8, hiTop8, loTop8;

  assign resTop4 = partRes[RES_W-1 -: EARLY_W];
  assign hiTop4  = limHigh[RES_W-1 -: EARLY_W];
  assign loTop4  = limLow[RES_W-1 -: EARLY_W];
  assign resTop8 = partRes[RES_W-1 -: LATE_W];
  assign hiTop8  = limHigh[RES_W-1 -: LATE_W];
  assign loTop8  = limLow[RES_W-1 -: LATE_W];

  assign earlyOut = outsideMode && ((resTop4 > hiTop4) || (resTop4 < loTop4));
  assign lateOut  = outsideMode && ((resTop8 > hiTop8) || (resTop8 < loTop8));
  assign fullIn   = !outsideMode && (partRes >= limLow) && (partRes <= limHigh);

  assign hit = bndEn && !fired &&
               ((strobe.evalEarly && earlyOut) ||
                (strobe.evalLate  && lateOut)  ||
                (strobe.evalFull  && fullIn));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanReg <= '0;
      fired   <= 1'b0;
      bndIrq  <= 1'b0;
    end else begin
      bndIrq <= hit;
      if (strobe.newConv) begin
        chanReg <= chanSel;
        fired   <= 1'b0;
      end else if (hit) begin
        fired <= 1'b1;
      end
    end
  end

  // One flag per channel: set has priority over write-one-to-clear
  for (genvar c = 0; c < CHAN_N; c++) begin : g_flag
    assign chanOneHot[c] = (chanReg == CHAN_W'(c));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        bndStatus[c] <= 1'b0;
      end else if (hit && chanOneHot[c]) begin
        bndStatus[c] <= 1'b1;
      end else if (clrWe && clrMask[c]) begin
        bndStatus[c] <= 1'b0;
      end
    end
  end

  // R4
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bndEn |=> !bndIrq);

  // R5
  single_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    fired |=> !bndIrq);

  // R10
  inside_last_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bndIrq && !$past(outsideMode)) |-> $past(strobe.evalFull));

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> ((bndStatus & $past(chanOneHot)) != '0));

  // R6
  clear_works_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrWe && !hit) |=> ((bndStatus & $past(clrMask)) == '0));
endmodule

// File: rtl/limit_window_monitor.sv
module limit_window_monitor
  import lwm_pkg::*;
#(
  parameter int RES_W   = 10,
  parameter int CHAN_N  = 8,
  parameter int EARLY_W = 4,
  parameter int LATE_W  = 8,
  localparam int CHAN_W = $clog2(CHAN_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convStart,
  input  logic              bitValid,
  input  logic [RES_W-1:0]  partRes,
  input  logic [CHAN_W-1:0] chanSel,
  input  logic              outsideMode,
  input  logic              bndEn,
  input  logic [RES_W-1:0]  limHigh,
  input  logic [RES_W-1:0]  limLow,
  input  logic              clrWe,
  input  logic [CHAN_N-1:0] clrMask,
  output logic              bndIrq,
  output logic [CHAN_N-1:0] bndStatus
);
  lwmStrobe_t strobe;

  lwm_ctrl #(
    .RES_W(RES_W), .EARLY_W(EARLY_W), .LATE_W(LATE_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .convStart(convStart),
    .bitValid(bitValid), .strobe(strobe)
  );

  lwm_datapath #(
    .RES_W(RES_W), .CHAN_N(CHAN_N), .EARLY_W(EARLY_W), .LATE_W(LATE_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .partRes(partRes),
    .chanSel(chanSel), .outsideMode(outsideMode), .bndEn(bndEn),
    .limHigh(limHigh), .limLow(limLow), .clrWe(clrWe), .clrMask(clrMask),
    .bndIrq(bndIrq), .bndStatus(bndStatus)
  );
endmodule

// File: tb/limit_window_monitor_tb_top.sv
module limit_window_monitor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RES_W = 10;
  localparam int CHAN_N = 8;
  localparam logic [RES_W-1:0] HIGH = 10'h2C0;  // top4 1011, top8 0xB0
  localparam logic [RES_W-1:0] LOW  = 10'h160;  // top4 0101, top8 0x58

  typedef struct packed {
    logic       outside;
    logic       en;
    logic [2:0] chan;
    logic [9:0] res;
    int         expBeat;   // bit index after which the pulse appears, -1 none
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 3'd0, 10'h200, 9},   // R1 inside
    '{1'b0, 1'b1, 3'd1, 10'h2C0, 9},   // R1 equal high
    '{1'b0, 1'b1, 3'd2, 10'h160, 9},   // R1 equal low
    '{1'b0, 1'b1, 3'd3, 10'h2C1, -1},  // R1 just above
    '{1'b0, 1'b1, 3'd3, 10'h15F, -1},  // R1 just below
    '{1'b1, 1'b1, 3'd4, 10'h3C0, 3},   // R2 early high, R5 late also true
    '{1'b1, 1'b1, 3'd5, 10'h0C0, 3},   // R2 early low
    '{1'b1, 1'b1, 3'd6, 10'h2D0, 7},   // R3 late high
    '{1'b1, 1'b1, 3'd7, 10'h150, 7},   // R3 late low
    '{1'b1, 1'b1, 3'd2, 10'h2C3, -1},  // R3 only 8 MSBs used
    '{1'b1, 1'b1, 3'd2, 10'h200, -1},  // R3 inside in outside mode
    '{1'b1, 1'b0, 3'd3, 10'h3C0, -1},  // R4 disabled outside
    '{1'b0, 1'b0, 3'd3, 10'h200, -1}   // R4 disabled inside
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic convStart = 1'b0, bitValid = 1'b0;
  logic [RES_W-1:0] partRes = '0;
  logic [2:0] chanSel = '0;
  logic outsideMode = 1'b0, bndEn = 1'b0;
  logic [RES_W-1:0] limHigh = HIGH, limLow = LOW;
  logic clrWe = 1'b0;
  logic [CHAN_N-1:0] clrMask = '0;
  logic bndIrq;
  logic [CHAN_N-1:0] bndStatus;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [CHAN_N-1:0] expStatus = '0;
  int pulses;
  int firstBeat;

  always #(CLK_PERIOD/2) clk = ~clk;

  limit_window_monitor dut_i (
    .clk(clk), .rstN(rstN), .convStart(convStart), .bitValid(bitValid),
    .partRes(partRes), .chanSel(chanSel), .outsideMode(outsideMode),
    .bndEn(bndEn), .limHigh(limHigh), .limLow(limLow), .clrWe(clrWe),
    .clrMask(clrMask), .bndIrq(bndIrq), .bndStatus(bndStatus)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One conversion; lastClr is written together with the final bit
  task automatic runConv(input logic outs, input logic en, input logic [2:0] ch,
                         input logic [RES_W-1:0] res, input logic [CHAN_N-1:0] lastClr);
    pulses = 0;
    firstBeat = -1;
    @(negedge clk);
    outsideMode = outs; bndEn = en; chanSel = ch; convStart = 1'b1;
    @(negedge clk);
    convStart = 1'b0;
    chanSel = ~ch;   // latched value must be used
    for (int k = 0; k < RES_W; k++) begin
      bitValid = 1'b1;
      partRes  = res & ~(10'h3FF >> (k + 1));
      if (k == RES_W - 1 && lastClr != '0) begin
        clrWe = 1'b1; clrMask = lastClr;
      end
      @(negedge clk);
      clrWe = 1'b0; clrMask = '0;
      if (bndIrq) begin
        pulses++;
        if (firstBeat < 0) firstBeat = k;
      end
    end
    bitValid = 1'b0; partRes = '0;
    @(negedge clk);
    if (bndIrq) pulses++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check(bndIrq == 1'b0, "R8 irq", bndIrq, 0);
    check(bndStatus == '0, "R8 status", bndStatus, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      runConv(VECS[i].outside, VECS[i].en, VECS[i].chan, VECS[i].res, '0);
      if (VECS[i].expBeat >= 0) expStatus[VECS[i].chan] = 1'b1;
      // R5 R9 pulse count and position
      check(pulses == (VECS[i].expBeat >= 0 ? 1 : 0), "R5 pulse count",
            pulses, VECS[i].expBeat >= 0 ? 1 : 0);
      check(firstBeat == VECS[i].expBeat, "R1 R2 R3 R10 decision bit",
            firstBeat, VECS[i].expBeat);
      check(bndStatus == expStatus, "R6 R4 status", bndStatus, expStatus);
    end

    // R6 write-one-to-clear of selected flags
    @(negedge clk);
    clrWe = 1'b1; clrMask = 8'h0F;
    @(negedge clk);
    clrWe = 1'b0; clrMask = '0;
    expStatus &= ~8'h0F;
    check(bndStatus == expStatus, "R6 partial clear", bndStatus, expStatus);

    // R7 hit on channel 5 while clearing everything
    runConv(1'b0, 1'b1, 3'd5, 10'h200, 8'hFF);
    check(bndStatus == 8'h20, "R7 set beats clear", bndStatus, 8'h20);

    // R9 bitValid together with convStart is ignored
    @(negedge clk);
    outsideMode = 1'b1; bndEn = 1'b1; chanSel = 3'd1;
    convStart = 1'b1; bitValid = 1'b1; partRes = 10'h200;
    @(negedge clk);
    convStart = 1'b0;
    pulses = 0;
    for (int k = 0; k < 4; k++) begin
      partRes = 10'h3C0 & ~(10'h3FF >> (k + 1));
      @(negedge clk);
      if (bndIrq) pulses++;
      if (k == 3) check(bndIrq == 1'b1, "R9 pulse after fourth real bit", bndIrq, 1);
    end
    bitValid = 1'b0;
    @(negedge clk);
    check(bndIrq == 1'b0, "R9 single-cycle pulse", bndIrq, 0);
    check(pulses == 1, "R9 pulse count", pulses, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule